// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol engine of a small serial EEPROM attached to a two-wire bus. It samples the bus clock and data lines with the system clock, passes them through a synchronizer, and detects the bus START and STOP conditions. After a START it shifts in a control byte, compares its device code and chip-select bits with fixed and strapped values, and answers with an acknowledge when they match and no program cycle is running. A following byte in a write transaction loads the internal word pointer. Later bytes are handed to an external page buffer.

Read transactions return bytes from a behavioural memory array. The engine fetches the byte at the pointer, shifts it out most significant bit first, and advances the pointer. It continues for as long as the master acknowledges. The pointer never leaves its 256-byte block. In the two-block configuration, the chip-select bit in the lowest slot is not compared with a strap. It selects the block instead. The data line is driven only through an open-drain pull-down enable.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, sda_oe_o, wr_valid_o and wr_commit_o are all low.
- R2: The control byte is sent MSB first. Its bits [7:4] must be 1010 and its bits [3:2] must equal strap_cs[2:1], or the block does not acknowledge it. Bit 0 is the read flag (0 = write).
- R3: When BLK_BITS=1, control bit 1 is not compared with strap_cs[0]. It becomes bit 8 of the word pointer.
- R4: A random read is a write control byte, a word address, a repeated START and a read control byte. It returns the byte at that word address.
- R5: While the master acknowledges each read byte, the block sends the byte at the next address.
- R6: The pointer increments only in its low 8 bits. After a block's last byte the read continues at the first byte of the same block.
- R7: A read with no preceding address phase starts at the address after the last byte sent.
- R8: Each data byte accepted in a write causes a one-cycle wr_valid_o pulse carrying the pointer and the byte, and the pointer then advances. A STOP after at least one accepted data byte gives a one-cycle wr_commit_o pulse.
- R9: While prog_busy_i is high, the control byte is not acknowledged and no wr_valid_o pulse occurs.
- R10: After the master does not acknowledge a read byte, sda_oe_o stays low until the next START. The pointer still holds the address after the last byte sent.
- R11: sda_oe_o is asserted only after SCL has been seen low.
- R12: The memory byte at address a is a[7:0] XOR 0x3C when a[8] is set, and a[7:0] otherwise.
- R13: A STOP in the middle of a byte returns the block to idle. The next transaction is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_cs | input | 3 | Strapped chip-select value |
| prog_busy_i | input | 1 | Program cycle in progress |
| sda_oe_o | output | 1 | Pull data line low when high |
| wr_valid_o | output | 1 | Write byte strobe to page buffer |
| wr_addr_o | output | AW (9) | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Launch program cycle |

## Verification
The hardest case to reach is the block wrap during a sequential read in the upper block. It needs the pointer's block bit to come from the control byte and the low byte to start just below the boundary. The stimulus selects the upper block through control bit 1 and loads word address 0xFE. It then reads three bytes with master acknowledges, so the third fetch shows whether bit 8 survived the increment. A STOP in the middle of a byte is produced by a hand-built partial byte followed by a STOP, and the transaction after it must decode normally.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_RX, S_RXEND, S_ACK, S_TX, S_MACK, S_MWAIT
   } twi_st_e;

   typedef enum logic [1:0] {
      K_CTRL, K_WADDR, K_WDATA
   } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            end
      end
   endgenerate

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
   parameter int         AW        = 9,
   parameter logic [7:0] UPPER_XOR = 8'h3C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= 8'(i) ^ ((i >= 256) ? UPPER_XOR : 8'h00);
      end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/twi_ctrl_core.sv
module twi_ctrl_core
   import twi_eeprom_pkg::*;
#(
   parameter int         AW       = 9,
   parameter int         BLK_BITS = 1,
   parameter logic [3:0] DEV_CODE = 4'b1010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [2:0]    strap_cs,
   input  logic          prog_busy_i,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] ptr_q,
   output logic          ptr_inc,
   output logic          ack_ctrl,
   output logic          sda_oe,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          wr_commit
);
   localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << 8;

   twi_st_e    st;
   rx_kind_e   kind;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic       is_read;
   logic       wrote;
   logic       hit;
   logic [AW-1:0] ptr_next;

   assign hit = (sh[7:4] == DEV_CODE) && (sh[3:2] == strap_cs[2:1]) &&
                ((sh[1] == strap_cs[0]) || (BLK_BITS == 1));
   assign ptr_next = (ptr_q & BLK_MASK) | ((ptr_q + 1'b1) & ~BLK_MASK);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st        <= S_IDLE;
         kind      <= K_CTRL;
         cnt       <= '0;
         sh        <= '0;
         is_read   <= 1'b0;
         wrote     <= 1'b0;
         ptr_q     <= '0;
         ptr_inc   <= 1'b0;
         ack_ctrl  <= 1'b0;
         sda_oe    <= 1'b0;
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
      end else begin
         wr_valid  <= 1'b0;
         wr_commit <= 1'b0;
         ptr_inc   <= 1'b0;
         if (start_det) begin
            st       <= S_RX;
            kind     <= K_CTRL;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            wrote    <= 1'b0;
            ack_ctrl <= 1'b0;
         end else if (stop_det) begin
            st        <= S_IDLE;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            wr_commit <= wrote;
            wrote     <= 1'b0;
            ack_ctrl  <= 1'b0;
         end else begin
            unique case (st)
               S_IDLE: ;
               S_RX:
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                     if (cnt == 4'd7) st <= S_RXEND;
                  end
               S_RXEND:
                  if (scl_fall) begin
                     unique case (kind)
                        K_CTRL:
                           if (hit && !prog_busy_i) begin
                              sda_oe   <= 1'b1;
                              ack_ctrl <= 1'b1;
                              is_read  <= sh[0];
                              if (BLK_BITS == 1) ptr_q[AW-1] <= sh[1];
                              st       <= S_ACK;
                           end else begin
                              st <= S_IDLE;
                           end
                        K_WADDR: begin
                           ptr_q[7:0] <= sh;
                           sda_oe     <= 1'b1;
                           st         <= S_ACK;
                        end
                        default:
                           if (!prog_busy_i) begin
                              wr_valid <= 1'b1;
                              wr_addr  <= ptr_q;
                              wr_data  <= sh;
                              ptr_q    <= ptr_next;
                              ptr_inc  <= 1'b1;
                              wrote    <= 1'b1;
                              sda_oe   <= 1'b1;
                              st       <= S_ACK;
                           end else begin
                              st <= S_IDLE;
                           end
                     endcase
                  end
               S_ACK:
                  if (scl_fall) begin
                     ack_ctrl <= 1'b0;
                     cnt      <= '0;
                     if (kind == K_CTRL && is_read) begin
                        sh      <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        ptr_q   <= ptr_next;
                        ptr_inc <= 1'b1;
                        st      <= S_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        kind   <= (kind == K_CTRL) ? K_WADDR : K_WDATA;
                        st     <= S_RX;
                     end
                  end
               S_TX: begin
                  if (scl_rise) cnt <= cnt + 4'd1;
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        st     <= S_MACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                     end
                  end
               end
               S_MACK:
                  if (scl_rise) st <= sda_s ? S_IDLE : S_MWAIT;
               S_MWAIT:
                  if (scl_fall) begin
                     cnt     <= '0;
                     sh      <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     ptr_q   <= ptr_next;
                     ptr_inc <= 1'b1;
                     st      <= S_TX;
                  end
               default: st <= S_IDLE;
            endcase
         end
      end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int         BLK_BITS    = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010,
   parameter logic [7:0] UPPER_XOR   = 8'h3C,
   localparam int        AW          = 8 + BLK_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic [2:0]    strap_cs,
   input  logic          prog_busy_i,
   output logic          sda_oe_o,
   output logic          wr_valid_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [7:0]    wr_data_o,
   output logic          wr_commit_o
);
   generate
      if (BLK_BITS < 0 || BLK_BITS > 1) begin : g_bad_blk
         $error("BLK_BITS must be 0 or 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [AW-1:0] ptr_q;
   logic          ptr_inc, ack_ctrl;
   logic [7:0]    rd_data;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_mem_array #(.AW(AW), .UPPER_XOR(UPPER_XOR)) u_mem (
      .clk(clk), .rst_n(rst_n), .rd_addr(ptr_q), .rd_data(rd_data)
   );

   twi_ctrl_core #(.AW(AW), .BLK_BITS(BLK_BITS), .DEV_CODE(DEV_CODE)) u_core (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .strap_cs(strap_cs), .prog_busy_i(prog_busy_i), .rd_data(rd_data),
      .ptr_q(ptr_q), .ptr_inc(ptr_inc), .ack_ctrl(ack_ctrl),
      .sda_oe(sda_oe_o), .wr_valid(wr_valid_o), .wr_addr(wr_addr_o),
      .wr_data(wr_data_o), .wr_commit(wr_commit_o)
   );
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          sda_oe,
   input logic          prog_busy_i,
   input logic          ack_ctrl,
   input logic          wr_valid,
   input logic          ptr_inc,
   input logic [AW-1:0] ptr
);
   // R11
   oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !$past(sda_oe)) |-> !$past(scl_s));

   // R9
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_ctrl) |-> !$past(prog_busy_i));

   // R9
   busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !$past(prog_busy_i));

   // R6
   block_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_inc |-> (((ptr ^ $past(ptr)) >> 8) == '0));
endmodule

bind twi_eeprom_slave twi_eeprom_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
   .prog_busy_i(prog_busy_i), .ack_ctrl(ack_ctrl), .wr_valid(wr_valid_o),
   .ptr_inc(ptr_inc), .ptr(ptr_q)
);

// File: tb/sim_twi_eeprom_slave.sv
module sim_twi_eeprom_slave;
   localparam int H = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [2:0] strap_cs = 3'b101;
   logic prog_busy = 1'b0;
   logic sda_oe, wr_valid, wr_commit;
   logic [8:0] wr_addr;
   logic [7:0] wr_data;
   logic sda_bus;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int wr_cnt = 0;
   int commit_cnt = 0;
   logic [8:0] first_wa, last_wa;
   logic [7:0] first_wd, last_wd;

   assign sda_bus = m_sda & ~sda_oe;

   always #4 clk = ~clk;

   twi_eeprom_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .strap_cs(strap_cs), .prog_busy_i(prog_busy), .sda_oe_o(sda_oe),
      .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_commit_o(wr_commit)
   );

   always @(posedge clk) begin
      if (wr_valid) begin
         if (wr_cnt == 0) begin
            first_wa <= wr_addr;
            first_wd <= wr_data;
         end
         last_wa <= wr_addr;
         last_wd <= wr_data;
         wr_cnt  <= wr_cnt + 1;
      end
      if (wr_commit) commit_cnt <= commit_cnt + 1;
   end

   function automatic logic [7:0] exp_mem(input logic [8:0] a);
      return a[7:0] ^ (a[8] ? 8'h3C : 8'h00);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bstart;
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(5);
   endtask

   task automatic bstop;
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic bbit(input logic b);
      m_sda = b; tick(H - 5);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(5);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bbit(b[i]);
      m_sda = 1'b1; tick(H - 5);
      m_scl = 1'b1; tick(H / 2);
      ack = ~sda_bus; tick(H / 2);
      m_scl = 1'b0; tick(5);
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H - 5);
         m_scl = 1'b1; tick(H / 2);
         b[i] = sda_bus; tick(H / 2);
         m_scl = 1'b0; tick(5);
      end
      m_sda = ~give_ack; tick(H - 5);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(5);
      m_sda = 1'b1;
   endtask

   task automatic set_ptr(input logic [7:0] ctrl_w, input logic [7:0] wa);
      logic a;
      bstart; wbyte(ctrl_w, a);
      chk("R2 ctrl ack", 16'(a), 16'h1);
      wbyte(wa, a);
      chk("R4 word address ack", 16'(a), 16'h1);
   endtask

   task automatic t_reset;
      chk("R1 sda_oe", 16'(sda_oe), 16'h0);
      chk("R1 wr_valid", 16'(wr_valid), 16'h0);
      chk("R1 wr_commit", 16'(wr_commit), 16'h0);
   endtask

   task automatic t_match;
      logic a;
      bstart; wbyte(8'hB8, a); bstop;
      chk("R2 wrong device code", 16'(a), 16'h0);
      bstart; wbyte(8'hAC, a); bstop;
      chk("R2 wrong chip bits", 16'(a), 16'h0);
      bstart; wbyte(8'hA8, a); bstop;
      chk("R3 A0 slot not compared", 16'(a), 16'h1);
   endtask

   task automatic t_random_seq;
      logic a;
      logic [7:0] d;
      set_ptr(8'hA8, 8'h10);
      bstart; wbyte(8'hA9, a);
      chk("R4 read ctrl ack", 16'(a), 16'h1);
      rbyte(1'b1, d); chk("R4 R12 random read", 16'(d), 16'(exp_mem(9'h010)));
      rbyte(1'b1, d); chk("R5 sequential 1", 16'(d), 16'(exp_mem(9'h011)));
      rbyte(1'b0, d); chk("R5 sequential 2", 16'(d), 16'(exp_mem(9'h012)));
      bstop;
   endtask

   task automatic t_current;
      logic a;
      logic [7:0] d;
      bstart; wbyte(8'hA9, a);
      rbyte(1'b0, d); bstop;
      chk("R7 current address", 16'(d), 16'(exp_mem(9'h013)));
   endtask

   task automatic t_wrap;
      logic a;
      logic [7:0] d;
      set_ptr(8'hAA, 8'hFE);
      bstart; wbyte(8'hAB, a);
      rbyte(1'b1, d); chk("R3 R12 upper block read", 16'(d), 16'(exp_mem(9'h1FE)));
      rbyte(1'b1, d); chk("R6 last of block", 16'(d), 16'(exp_mem(9'h1FF)));
      rbyte(1'b0, d); chk("R6 wrap to block start", 16'(d), 16'(exp_mem(9'h100)));
      bstop;
   endtask

   task automatic t_write;
      logic a;
      set_ptr(8'hA8, 8'h40);
      wbyte(8'h77, a); chk("R8 data ack 1", 16'(a), 16'h1);
      wbyte(8'h88, a); chk("R8 data ack 2", 16'(a), 16'h1);
      bstop; tick(5);
      chk("R8 write count", 16'(wr_cnt), 16'd2);
      chk("R8 first addr", 16'(first_wa), 16'h040);
      chk("R8 first data", 16'(first_wd), 16'h77);
      chk("R8 second addr", 16'(last_wa), 16'h041);
      chk("R8 second data", 16'(last_wd), 16'h88);
      chk("R8 commit", 16'(commit_cnt), 16'd1);
   endtask

   task automatic t_busy;
      logic a;
      prog_busy = 1'b1;
      bstart; wbyte(8'hA8, a);
      chk("R9 no ack while busy", 16'(a), 16'h0);
      wbyte(8'h50, a); wbyte(8'h99, a); bstop; tick(5);
      chk("R9 no write while busy", 16'(wr_cnt), 16'd2);
      chk("R9 no commit while busy", 16'(commit_cnt), 16'd1);
      prog_busy = 1'b0;
   endtask

   task automatic t_nack;
      logic a;
      logic [7:0] d;
      set_ptr(8'hA8, 8'h7F);
      bstart; wbyte(8'hA9, a);
      rbyte(1'b0, d);
      chk("R10 byte before nack", 16'(d), 16'(exp_mem(9'h07F)));
      chk("R10 released after nack", 16'(sda_oe), 16'h0);
      m_scl = 1'b1; tick(H / 2);
      chk("R10 released in next high", 16'(sda_oe), 16'h0);
      tick(H / 2); m_scl = 1'b0; tick(5);
      bstop;
      bstart; wbyte(8'hA9, a); rbyte(1'b0, d); bstop;
      chk("R10 pointer after nack", 16'(d), 16'(exp_mem(9'h080)));
   endtask

   task automatic t_abort;
      logic a;
      bstart;
      bbit(1'b1); bbit(1'b0); bbit(1'b1); bbit(1'b0);
      bstop;
      bstart; wbyte(8'hA8, a); bstop;
      chk("R13 decode after aborted byte", 16'(a), 16'h1);
   endtask

   initial begin
      tick(10);
      t_reset;
      rst_n = 1'b1;
      tick(10);
      t_match;
      t_random_seq;
      t_current;
      t_wrap;
      t_write;
      t_busy;
      t_nack;
      t_abort;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule